// File: doc/BRIEF.md
# Phase Recovery Fence Averaging Sequencer

This block runs one fence calibration step against a phase recovery engine over a simple request/acknowledge register port. After a start pulse it seeds nine recovery slots with a 5-bit value and pulses the engine's training enable for a fixed number of clocks. It then reads back the nine 7-bit recovered phases and forms their average with a small sequential divide-by-9.

A revision-dependent offset is subtracted from the average, with a clamp at zero. The 5-bit result goes into the fence field of a control word through read-modify-write. The sequence ends by reading the address/command timing word and writing it back unchanged. A one-cycle done pulse marks the end, and the computed fence value stays on an output port.

Top module: `fence_train_seq`

## Requirements
- R1: After reset, `done` and `reg_req` are 0 and `fence_out` is 0.
- R2: `start` is acted on only while idle. A start pulse during a run has no effect, and each run makes exactly 13 register accesses.
- R3: The accesses come in this order, with default addresses: write 0x50, write 0x51, write 0x52, read 0x08, write 0x08 (enable set), write 0x08 (enable clear), read 0x50, read 0x51, read 0x52, read 0x0C, write 0x0C, read 0x04, write 0x04.
- R4: The seed is captured at start. Words 0x50 and 0x51 carry the zero-extended seed in each of their four bytes. Word 0x52 carries it in bits 7:0, and all its other bits are zero.
- R5: The set write to 0x08 is the read value with bit 1 set. The clear write is the read value with bit 1 cleared. The clear request is first raised exactly WAIT_CYC (default 200) cycles after the edge that accepts the set write.
- R6: Only bits 6:0 of each byte of 0x50 and 0x51, and bits 6:0 of byte 0 of 0x52, are summed. Bit 7 of every byte and bits 31:8 of 0x52 have no effect.
- R7: The average is the sum of the nine slots divided by 9, rounded down.
- R8: The offset is selected by `rev_sel` (0→8, 1→6, 2→5, 3→0) and captured at start. The result is the low 5 bits of average minus offset, or 0 when the average is below the offset.
- R9: The write to 0x0C equals the word just read with bits 20:16 replaced by the result. `fence_out` holds the same result.
- R10: The write to 0x04 equals the value just read from 0x04.
- R11: Each request holds its address, direction and write data stable until `reg_ack`, and each acknowledge completes one access.
- R12: `done` is high for exactly one cycle, in the cycle after the edge that accepts the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (idle only) |
| seed | input | 5 | Seed written to all recovery slots |
| rev_sel | input | 2 | Selects the subtracted offset |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access accepted, read data valid |
| reg_rdata | input | 32 | Read data |
| fence_out | output | 5 | Last computed fence value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to reach are the two ends of the offset step: averages below the offset, which must clamp to zero, and large averages whose difference overflows the 5-bit field and must wrap. Both are reached by sweeping a uniform recovered value from 0 to 127 while rotating the revision select. Mixed per-slot patterns then check the floor division. Stray high bits are planted in every byte and in the upper part of the third word, so any leak into the sum changes the result. The bench's engine model timestamps the enable set and clear writes to pin the hold window to the cycle, and a start pulse is injected mid-run to show it is ignored.

// File: rtl/fence_train_seq.sv
module fence_train_seq #(
  parameter int SEED_W   = 5,
  parameter int VAL_W    = 7,
  parameter int FLD_W    = 5,
  parameter int FLD_LSB  = 16,
  parameter int WAIT_CYC = 200,
  parameter int TRN_BIT  = 1,
  parameter int AW       = 8,
  parameter logic [AW-1:0] A_CTL   = 8'h08,
  parameter logic [AW-1:0] A_FENCE = 8'h0C,
  parameter logic [AW-1:0] A_ACMD  = 8'h04,
  parameter logic [AW-1:0] A_REC   = 8'h50,
  parameter int OFF0 = 8,
  parameter int OFF1 = 6,
  parameter int OFF2 = 5,
  parameter int OFF3 = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEED_W-1:0] seed,
  input  logic [1:0]        rev_sel,
  output logic              reg_req,
  output logic              reg_we,
  output logic [AW-1:0]     reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata,
  output logic [FLD_W-1:0]  fence_out,
  output logic              done
);
  localparam int SUM_W = $clog2(9 * ((1 << VAL_W) - 1) + 1);
  localparam int CW    = $clog2(WAIT_CYC + 1);
  localparam logic [31:0] FMASK = ((32'd1 << FLD_W) - 32'd1) << FLD_LSB;
  localparam logic [31:0] TMASK = 32'd1 << TRN_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_SEED, S_CRD, S_CSET, S_WAIT, S_CCLR, S_HARV,
    S_DIV, S_FRD, S_FWR, S_ARD, S_AWR, S_DONE
  } st_t;

  st_t               st;
  logic [1:0]        idx;
  logic [CW-1:0]     cnt;
  logic [31:0]       word;
  logic [SUM_W-1:0]  sum, rem;
  logic [VAL_W-1:0]  quo, off_v;
  logic [SEED_W-1:0] seed_q;
  logic [1:0]        rev_q;
  logic [FLD_W-1:0]  fence_q, res;
  logic [7:0]        sbyte;
  logic [SUM_W-1:0]  part;

  assign sbyte     = 8'(seed_q);
  assign fence_out = fence_q;
  assign done      = (st == S_DONE);

  always_comb begin
    case (rev_q)
      2'd0:    off_v = VAL_W'(OFF0);
      2'd1:    off_v = VAL_W'(OFF1);
      2'd2:    off_v = VAL_W'(OFF2);
      default: off_v = VAL_W'(OFF3);
    endcase
  end

  assign res = (quo >= off_v) ? FLD_W'(quo - off_v) : '0;

  always_comb begin
    part = SUM_W'(reg_rdata[VAL_W-1:0]);
    if (idx != 2'd2)
      for (int b = 1; b < 4; b++)
        part = part + SUM_W'(reg_rdata[8*b +: VAL_W]);
  end

  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    case (st)
      S_SEED: begin
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_REC + AW'(idx);
        reg_wdata = (idx == 2'd2) ? {24'd0, sbyte} : {4{sbyte}};
      end
      S_CRD:  begin reg_req = 1'b1; reg_addr = A_CTL; end
      S_CSET: begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = word | TMASK; end
      S_CCLR: begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = word & ~TMASK; end
      S_HARV: begin reg_req = 1'b1; reg_addr = A_REC + AW'(idx); end
      S_FRD:  begin reg_req = 1'b1; reg_addr = A_FENCE; end
      S_FWR:  begin
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_FENCE;
        reg_wdata = (word & ~FMASK) | (32'(fence_q) << FLD_LSB);
      end
      S_ARD:  begin reg_req = 1'b1; reg_addr = A_ACMD; end
      S_AWR:  begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = A_ACMD; reg_wdata = word; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; word <= '0; sum <= '0; rem <= '0;
      quo <= '0; seed_q <= '0; rev_q <= '0; fence_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          seed_q <= seed; rev_q <= rev_sel; idx <= '0; st <= S_SEED;
        end
        S_SEED: if (reg_ack) begin
          if (idx == 2'd2) begin idx <= '0; st <= S_CRD; end
          else idx <= idx + 2'd1;
        end
        S_CRD:  if (reg_ack) begin word <= reg_rdata; st <= S_CSET; end
        S_CSET: if (reg_ack) begin cnt <= '0; st <= S_WAIT; end
        S_WAIT: begin
          if (cnt == CW'(WAIT_CYC - 1)) st <= S_CCLR;
          else cnt <= cnt + CW'(1);
        end
        S_CCLR: if (reg_ack) begin idx <= '0; sum <= '0; st <= S_HARV; end
        S_HARV: if (reg_ack) begin
          if (idx == 2'd2) begin
            rem <= sum + part; quo <= '0; st <= S_DIV;
          end else begin
            sum <= sum + part; idx <= idx + 2'd1;
          end
        end
        S_DIV: begin
          if (rem >= SUM_W'(9)) begin rem <= rem - SUM_W'(9); quo <= quo + VAL_W'(1); end
          else begin fence_q <= res; st <= S_FRD; end
        end
        S_FRD: if (reg_ack) begin word <= reg_rdata; st <= S_FWR; end
        S_FWR: if (reg_ack) st <= S_ARD;
        S_ARD: if (reg_ack) begin word <= reg_rdata; st <= S_AWR; end
        S_AWR: if (reg_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_DIV) |-> !reg_req);

  // R9
  fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_DIV) |=> $stable(fence_out));

  // R12
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(reg_ack && reg_we && reg_addr == A_ACMD));
endmodule

// File: tb/fence_train_seq_test.sv
module fence_train_seq_test;
  localparam int CLK_PER = 10;
  localparam int WAITN   = 200;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0]  seed = '0;
  logic [1:0]  rev_sel = '0;
  logic        reg_req, reg_we, done;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_ack = 1'b0;
  logic [31:0] reg_rdata = '0;
  logic [4:0]  fence_out;

  fence_train_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .rev_sel(rev_sel),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .fence_out(fence_out), .done(done));

  always #(CLK_PER/2) clk = ~clk;

  int total = 0, bad = 0;
  int ncount = 0;
  bit timeout = 0;
  logic [31:0] ctl_m, fence_m, acmd_m;
  logic [31:0] hv [3];
  logic [7:0]  log_a [16];
  logic        log_w [16];
  logic [31:0] log_d [16];
  int nacc, set_cyc, clr_cyc, last_ack, done_cyc, done_cnt;
  bit dbl_done;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ncount++;
    if (ncount > 190000) timeout = 1;
    if (done) begin
      if (done_cyc == ncount - 1) dbl_done = 1;
      done_cyc = ncount; done_cnt++;
    end
    if (reg_ack) reg_ack = 1'b0;
    else if (reg_req) begin
      if (nacc < 16) begin log_a[nacc] = reg_addr; log_w[nacc] = reg_we; log_d[nacc] = reg_wdata; end
      if (reg_we) begin
        case (reg_addr)
          8'h08: begin ctl_m = reg_wdata; if (reg_wdata[1]) set_cyc = ncount; else clr_cyc = ncount; end
          8'h0C: fence_m = reg_wdata;
          8'h04: acmd_m = reg_wdata;
          default: ;
        endcase
      end else begin
        case (reg_addr)
          8'h08: reg_rdata = ctl_m;
          8'h0C: reg_rdata = fence_m;
          8'h04: reg_rdata = acmd_m;
          8'h50: reg_rdata = hv[0];
          8'h51: reg_rdata = hv[1];
          8'h52: reg_rdata = hv[2];
          default: reg_rdata = 32'hBAD0_BAD0;
        endcase
      end
      last_ack = ncount; nacc++; reg_ack = 1'b1;
    end
  endtask

  function automatic int off_of(input int r);
    case (r) 0: return 8; 1: return 6; 2: return 5; default: return 0; endcase
  endfunction

  task automatic run_one(input logic [4:0] sd, input int rv, input int sl [9], input bit garb,
                         input logic [31:0] ci, input logic [31:0] fi, input logic [31:0] ai,
                         input bit inject);
    logic [7:0] g;
    int sum, avg, res, off, n;
    logic [7:0] ea [13];
    bit ew [13];
    int mis;
    g = garb ? 8'h80 : 8'h00;
    hv[0] = {g | 8'(sl[3]), g | 8'(sl[2]), g | 8'(sl[1]), g | 8'(sl[0])};
    hv[1] = {g | 8'(sl[7]), g | 8'(sl[6]), g | 8'(sl[5]), g | 8'(sl[4])};
    hv[2] = {(garb ? 24'hA5C3FF : 24'h000000), g | 8'(sl[8])};
    ctl_m = ci; fence_m = fi; acmd_m = ai;
    nacc = 0; set_cyc = -1; clr_cyc = -1; done_cyc = -1000; done_cnt = 0; dbl_done = 0;
    seed = sd; rev_sel = 2'(rv);
    start = 1'b1; tick(); start = 1'b0;
    seed = ~sd; rev_sel = ~2'(rv);
    n = 0;
    while (done_cnt == 0 && !timeout && n < 3000) begin
      start = (inject && n == 40);
      tick(); n++;
    end
    start = 1'b0;
    tick(); tick();
    sum = 0;
    for (int i = 0; i < 9; i++) sum += sl[i];
    avg = sum / 9; off = off_of(rv);
    res = (avg >= off) ? ((avg - off) & 31) : 0;
    // R2
    chk(nacc == 13 && done_cnt == 1, "R2 access count", 32'(nacc), 32'd13);
    ea = '{8'h50,8'h51,8'h52,8'h08,8'h08,8'h08,8'h50,8'h51,8'h52,8'h0C,8'h0C,8'h04,8'h04};
    ew = '{1,1,1,0,1,1,0,0,0,0,1,0,1};
    mis = -1;
    for (int i = 12; i >= 0; i--) if (log_a[i] != ea[i] || log_w[i] != ew[i]) mis = i;
    chk(mis < 0, "R3 R11 access order", (mis < 0) ? 32'd0 : 32'(log_a[mis]), (mis < 0) ? 32'd0 : 32'(ea[mis]));
    chk(log_d[0] == {4{3'b0, sd}} && log_d[1] == {4{3'b0, sd}}, "R4 seed words", log_d[0], {4{3'b0, sd}});
    chk(log_d[2] == {27'd0, sd}, "R4 seed third word", log_d[2], {27'd0, sd});
    chk(log_d[4] == (ci | 32'h2), "R5 enable set", log_d[4], ci | 32'h2);
    chk(log_d[5] == (ci & ~32'h2), "R5 enable clear", log_d[5], ci & ~32'h2);
    chk(clr_cyc - set_cyc == WAITN + 1, "R5 enable window", 32'(clr_cyc - set_cyc), 32'(WAITN + 1));
    chk(fence_out == 5'(res), "R6 R7 R8 fence value", 32'(fence_out), 32'(res));
    chk(log_d[10] == ((fi & ~32'h001F_0000) | (32'(res) << 16)), "R9 fence word", log_d[10],
        (fi & ~32'h001F_0000) | (32'(res) << 16));
    chk(log_d[12] == ai, "R10 write-back", log_d[12], ai);
    chk(done_cyc - last_ack == 1 && !dbl_done, "R12 done timing", 32'(done_cyc - last_ack), 32'd1);
  endtask

  initial begin
    int sl [9];
    tick(); tick(); tick();
    // R1
    chk(done == 1'b0 && reg_req == 1'b0 && fence_out == 5'd0, "R1 reset state",
        {30'd0, done, reg_req}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk(done == 1'b0 && reg_req == 1'b0 && fence_out == 5'd0, "R1 idle after reset",
        {27'd0, fence_out}, 32'd0);
    for (int v = 0; v < 128 && !timeout; v++) begin
      for (int i = 0; i < 9; i++) sl[i] = v;
      run_one(5'(v), v % 4, sl, v[0], (v[1] ? 32'h8000_0002 : 32'h0F0F_0F0D),
              (v[2] ? 32'hFFFF_FFFF : 32'h1234_5678), 32'(v) * 32'h0101_0101 ^ 32'hDEAD_0000, 1'b0);
    end
    for (int k = 0; k < 24 && !timeout; k++) begin
      for (int i = 0; i < 9; i++) sl[i] = (k * 37 + i * 29 + 11 + i * i * k) & 127;
      run_one(5'(k * 7), k % 4, sl, k[0], 32'(k) * 32'h1111_1111, 32'hA5A5_5A5A ^ 32'(k),
              32'hCAFE_0000 | 32'(k), (k % 3) == 0);
    end
    if (timeout) begin total++; bad++; $display("FAIL watchdog expired"); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule